// File: doc/BRIEF.md
# Two-level alternating request arbiter

This block decides which of three requesters owns a shared bus-mastering engine. One requester is a target path that forwards transactions arriving from an external bus. The other two are DMA channels that move data in opposite directions. Each requester raises a request line while it has work and pulses a done line when its transaction is finished. The block answers with one-hot grants.

Priority alternates on two nested levels. At the top level the target path and the DMA group take turns. Inside the DMA group the two channels take turns with each other. When all three requesters stay busy, the target path (the low-bandwidth class) wins about half of the turns and each DMA channel (the high-bandwidth class) wins about a quarter. A grant stays with its owner until that owner signals done. The cycle after done is left free of grants, and the next decision is made in that cycle.

Top module: `alt_arb`

## Requirements
- R1: At most one grant is high in any cycle. During the active-low synchronous reset, and right after it, all grants are low. After reset the target path is preferred at the top level and DMA channel 0 is preferred inside the DMA group.
- R2: When no grant is held and at least one request is high at a rising clock edge, exactly one grant is high from that edge onward.
- R3: If the target path and at least one DMA channel are both requesting, the side the top-level flag prefers wins. If only one side is requesting, that side wins. After any grant at the top level, the flag prefers the side that did not win.
- R4: If the DMA group wins and both channels are requesting, the preferred channel wins. If only one channel is requesting, that channel wins. After a DMA grant, the channel that did not win becomes preferred.
- R5: The DMA-level flag changes only when a DMA channel receives a grant. A target-path grant leaves it unchanged.
- R6: A grant stays high until its owner pulses done. Done pulses from requesters that do not hold the grant have no effect on the grants.
- R7: The owner's done, sampled at a rising edge, clears the grant at that edge. The grants are then low for exactly one cycle when requests are still pending, and the next decision is made at the following edge.
- R8: While no requester is active, all grants stay low and both priority flags keep their values.
- R9: With all three requesters asserting continuously from reset, grants are issued in the repeating order target, DMA0, target, DMA1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| tgt_req | input | 1 | Target-path request |
| tgt_done | input | 1 | Target-path transaction complete pulse |
| dma_req | input | 2 | DMA channel requests, bit n for channel n |
| dma_done | input | 2 | DMA channel completion pulses, bit n for channel n |
| tgt_gnt | output | 1 | Grant to the target path |
| dma_gnt | output | 2 | Grants to the DMA channels, bit n for channel n |

## Verification
The bench builds the block with its only configuration: one target requester and two DMA channels. This small size makes it possible to sweep all eight request patterns several times. Each pass starts from different priority-flag states, so every pattern is met with each combination of the two flags that its history reaches. A free-running stress phase with all requesters busy checks the T, D0, T, D1 rotation and the one-cycle gap after each done. The bench also drives done pulses from requesters that do not hold the grant while a grant is held, to show that they are ignored.

// File: rtl/alt_arb_pkg.sv
package alt_arb_pkg;
  localparam int unsigned NUM_DMA = 2;
  localparam int unsigned NUM_REQ = NUM_DMA + 1;

  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_TGT  = 2'd1,
    OWN_DMA0 = 2'd2,
    OWN_DMA1 = 2'd3
  } owner_t;

  // Channel chosen inside the DMA group; meaningful only when a request is up.
  function automatic logic pick_dma_ch(input logic [NUM_DMA-1:0] req, input logic pref);
    if (req[pref]) return pref;
    return ~pref;
  endfunction

  // Grant vector layout: bit 0 target, bit 1 DMA0, bit 2 DMA1.
  function automatic logic [NUM_REQ-1:0] owner_to_gnt(input owner_t o);
    case (o)
      OWN_TGT:  return 3'b001;
      OWN_DMA0: return 3'b010;
      OWN_DMA1: return 3'b100;
      default:  return 3'b000;
    endcase
  endfunction
endpackage

// File: rtl/alt_arb_top_sel.sv
module alt_arb_top_sel (
  input  logic clk,
  input  logic rst_n,
  input  logic decide,
  input  logic tgt_req,
  input  logic dma_any,
  output logic tgt_win,
  output logic dma_win,
  output logic pref_dma
);
  always_comb begin
    tgt_win = decide && tgt_req && (!dma_any || !pref_dma);
    dma_win = decide && dma_any && !tgt_win;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       pref_dma <= 1'b0;
    else if (tgt_win) pref_dma <= 1'b1;
    else if (dma_win) pref_dma <= 1'b0;
  end

  assert_flag_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!tgt_req && !dma_any) |=> $stable(pref_dma));
endmodule

// File: rtl/alt_arb_dma_sel.sv
module alt_arb_dma_sel
  import alt_arb_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_DMA-1:0] dma_req,
  input  logic               take,
  output logic               win_ch,
  output logic               pref
);
  always_comb win_ch = pick_dma_ch(dma_req, pref);

  always_ff @(posedge clk) begin
    if (!rst_n)    pref <= 1'b0;
    else if (take) pref <= ~win_ch;
  end

  assert_dma_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(pref));
endmodule

// File: rtl/alt_arb_hold.sv
module alt_arb_hold
  import alt_arb_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  owner_t             next_owner,
  input  logic [NUM_REQ-1:0] done,
  output logic [NUM_REQ-1:0] gnt,
  output logic               idle
);
  owner_t owner;
  logic   owner_done;

  always_comb begin
    gnt        = owner_to_gnt(owner);
    idle       = (owner == OWN_NONE);
    owner_done = |(gnt & done);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          owner <= OWN_NONE;
    else if (idle)       owner <= next_owner;
    else if (owner_done) owner <= OWN_NONE;
  end

  assert_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((gnt != '0) && !owner_done) |=> (gnt == $past(gnt)));
  assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    owner_done |=> (gnt == '0));
endmodule

// File: rtl/alt_arb.sv
module alt_arb
  import alt_arb_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tgt_req,
  input  logic               tgt_done,
  input  logic [NUM_DMA-1:0] dma_req,
  input  logic [NUM_DMA-1:0] dma_done,
  output logic               tgt_gnt,
  output logic [NUM_DMA-1:0] dma_gnt
);
  logic               idle, dma_any, tgt_win, dma_win, pref_dma;
  logic               dma_take, dma_ch, dma_pref;
  logic [NUM_REQ-1:0] gnt_vec;
  owner_t             next_owner;

  always_comb begin
    dma_any  = |dma_req;
    dma_take = dma_win;
    if (tgt_win)      next_owner = OWN_TGT;
    else if (dma_win) next_owner = dma_ch ? OWN_DMA1 : OWN_DMA0;
    else              next_owner = OWN_NONE;
  end

  alt_arb_top_sel u_top (
    .clk(clk), .rst_n(rst_n), .decide(idle), .tgt_req(tgt_req),
    .dma_any(dma_any), .tgt_win(tgt_win), .dma_win(dma_win), .pref_dma(pref_dma)
  );

  alt_arb_dma_sel u_dma (
    .clk(clk), .rst_n(rst_n), .dma_req(dma_req), .take(dma_take),
    .win_ch(dma_ch), .pref(dma_pref)
  );

  alt_arb_hold u_hold (
    .clk(clk), .rst_n(rst_n), .next_owner(next_owner),
    .done({dma_done, tgt_done}), .gnt(gnt_vec), .idle(idle)
  );

  assign tgt_gnt = gnt_vec[0];
  assign dma_gnt = gnt_vec[NUM_REQ-1:1];

  assert_grant_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && (tgt_req || dma_any)) |=> ({dma_gnt, tgt_gnt} != '0));
  assert_top_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tgt_gnt) |-> pref_dma);
  assert_dma0_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_gnt[0]) |-> (dma_pref && !pref_dma));
  assert_dma1_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_gnt[1]) |-> (!dma_pref && !pref_dma));
endmodule

// File: tb/alt_arb_test.sv
`timescale 1ns/1ps
module alt_arb_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tgt_req = 1'b0, tgt_done = 1'b0;
  logic [1:0] dma_req = 2'b00, dma_done = 2'b00;
  logic       tgt_gnt;
  logic [1:0] dma_gnt;

  int  n_checks = 0;
  int  n_fail = 0;
  bit  finished = 1'b0;
  // model flags: m_top=1 means DMA group preferred, m_dch = preferred channel
  bit  m_top = 1'b0;
  bit  m_dch = 1'b0;

  always #2.5 clk = ~clk;

  alt_arb uut (
    .clk(clk), .rst_n(rst_n), .tgt_req(tgt_req), .tgt_done(tgt_done),
    .dma_req(dma_req), .dma_done(dma_done), .tgt_gnt(tgt_gnt), .dma_gnt(dma_gnt)
  );

  function automatic logic [2:0] gnts();
    return {dma_gnt, tgt_gnt};
  endfunction

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: grants actual %b expected %b", req, act, exp);
    end
  endtask

  // expected grant for request pattern r = {d1,d0,t}; also advances the model
  function automatic logic [2:0] predict(input logic [2:0] r);
    logic [2:0] g;
    bit dma_side;
    g = 3'b000;
    dma_side = (r[2:1] != 2'b00) && (!r[0] || m_top);
    if (!dma_side && r[0]) begin
      g = 3'b001;
      m_top = 1'b1;
    end else if (dma_side) begin
      if (r[1 + m_dch]) g = m_dch ? 3'b100 : 3'b010;
      else              g = m_dch ? 3'b010 : 3'b100;
      m_dch = g[1];
      m_top = 1'b0;
    end
    return g;
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    logic [2:0] e;
    logic [2:0] p;
    repeat (3) @(negedge clk);
    check("R1 reset", gnts(), 3'b000);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R1 after reset", gnts(), 3'b000);

    // R9 / R7: all busy continuously
    tgt_req = 1'b1; dma_req = 2'b11;
    for (int i = 0; i < 8; i++) begin
      @(posedge clk); @(negedge clk);
      e = (i % 2 == 0) ? 3'b001 : ((i % 4 == 1) ? 3'b010 : 3'b100);
      check("R9 rotation", gnts(), e);
      check("R3 R4 model", predict(3'b111), e);
      {dma_done, tgt_done} = e;
      @(posedge clk); @(negedge clk);
      check("R7 gap after done", gnts(), 3'b000);
      {dma_done, tgt_done} = 3'b000;
    end
    tgt_req = 1'b0; dma_req = 2'b00;
    @(posedge clk); @(negedge clk);
    check("R8 idle", gnts(), 3'b000);

    // sweep of request patterns from changing flag states
    for (int pass = 0; pass < 4; pass++) begin
      for (int k = 0; k < 8; k++) begin
        p = 3'((k * 3 + pass) & 7);
        {dma_req, tgt_req} = p;
        @(posedge clk); @(negedge clk);
        e = predict(p);
        check("R2 R3 R4 R5 decision", gnts(), e);
        if (e != 3'b000) begin
          for (int h = 0; h < 2; h++) begin
            {dma_done, tgt_done} = ~e;
            @(posedge clk); @(negedge clk);
            check("R6 hold vs foreign done", gnts(), e);
          end
          {dma_done, tgt_done} = e;
          {dma_req, tgt_req} = 3'b000;
          @(posedge clk); @(negedge clk);
          check("R7 release", gnts(), 3'b000);
          {dma_done, tgt_done} = 3'b000;
        end
        {dma_req, tgt_req} = 3'b000;
        @(posedge clk); @(negedge clk);
        check("R8 no request", gnts(), 3'b000);
      end
    end
    finish_run();
  end

  initial begin
    #500000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule